// File: doc/BRIEF.md
# CAN Message Interrupt Aggregator

This block sits between the message-slot logic of one CAN controller and the interrupt controller of the chip. Each of 15 message slots reports a successful frame with a one-cycle completion pulse and a direction bit (transmit or receive). The block keeps a sticky pending flag per slot and remembers the direction of the slot's last completion. Each pending flag is then masked by that slot's transmit-enable or receive-enable bit, according to that direction. All masked slot requests, together with an error-condition source and a status-condition source that each have their own enable, are ORed into one controller interrupt line. That line is gated by a global enable and a controller enable.

A separate bus-activity detector watches the asynchronous receive pins of two controllers. It synchronises them and latches a sticky flag on any falling edge, which is the change to the dominant level. It raises its own interrupt line.

Software configures the block and clears its flags through a simple write port. A write to the pending-clear register clears the flags of the slots whose data bits are 1. Hardware never clears a flag. The register addresses are fixed: 0 = transmit enables (bit i = slot i), 1 = receive enables, 2 = pending clear (write 1 to clear), 3 = control, 4 = activity clear (bit 0). The control register bits are: bit 0 global enable, bit 1 controller enable, bit 2 error enable, bit 3 status enable, bit 4 activity enable.

Top module: `can_msg_irq_agg`

## Requirements
- R1: After reset, all pending flags, the activity flag, `can_irq` and `act_irq` are 0, and all enable registers are 0.
- R2: A pulse on `done_pulse[i]` sets `pend_o[i]` at the next clock edge. The slot records `done_tx[i]` as its last direction (1 = transmit, 0 = receive).
- R3: A pending flag stays set until a write to address 2 with data bit i = 1. Writes with bit i = 0, and writes to other addresses, leave it unchanged.
- R4: If a completion pulse and a software clear hit the same slot in the same cycle, the flag ends up set.
- R5: Slot i requests an interrupt when its flag is set and the enable for its recorded direction (address 0 for transmit, address 1 for receive) has bit i = 1. The enable for the other direction has no effect.
- R6: `can_irq` can be 1 only when control bits 0 (global) and 1 (controller) are both 1. With both set, it is the OR of all slot requests and the gated error and status sources.
- R7: `err_cond` adds to the request only when control bit 2 is 1. `stat_cond` adds to the request only when control bit 3 is 1.
- R8: A falling edge on either `rx_pin` bit sets `act_flag_o` exactly SYNC_STAGES+1 clock edges after the pin changes. A rising edge does not set it.
- R9: `act_flag_o` is cleared by a write to address 4 with bit 0 = 1, and a new edge in the same cycle wins over the clear. `act_irq` = control bit 0 AND control bit 4 AND `act_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 15 | Write data |
| done_pulse | input | 15 | Per-slot completion pulse |
| done_tx | input | 15 | Per-slot completion direction (1 = transmit) |
| err_cond | input | 1 | Error-condition source |
| stat_cond | input | 1 | Status-condition source |
| rx_pin | input | 2 | Asynchronous receive pins of two controllers |
| can_irq | output | 1 | Controller interrupt |
| act_irq | output | 1 | Bus-activity interrupt |
| pend_o | output | 15 | Per-slot pending flags |
| act_flag_o | output | 1 | Bus-activity flag |

## Verification
The bench sweeps every slot with both completion directions against all four combinations of that slot's enables. A design that gated with the wrong enable, or ORed the two enables together, would raise the line for a direction software had masked. It then collides a completion with a clear on the same slot, and a bus edge with an activity clear. A design that let the clear win would drop an event. It also counts the exact edge at which a pin fall reaches the activity flag, and checks that a rising pin, a zero clear bit or a write to another register leaves the flags alone. It sweeps all sixteen error and status combinations and all four global and controller gate settings.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_TX_EN    = 3'd0,
        REG_RX_EN    = 3'd1,
        REG_PEND_CLR = 3'd2,
        REG_CTRL     = 3'd3,
        REG_ACT_CLR  = 3'd4
    } reg_addr_e;

    // Control register, bit 0 is glb_en
    typedef struct packed {
        logic act_en;
        logic stat_en;
        logic err_en;
        logic ctl_en;
        logic glb_en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    function automatic logic slot_request(input logic pend, input logic was_tx,
                                          input logic tx_en, input logic rx_en);
        return pend & (was_tx ? tx_en : rx_en);
    endfunction

endpackage

// File: rtl/can_slot_bank.sv
module can_slot_bank
    import can_irq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] done_pulse,
    input  logic [NUM_SLOTS-1:0] done_tx,
    input  logic [NUM_SLOTS-1:0] clr_vec,
    input  logic [NUM_SLOTS-1:0] tx_en,
    input  logic [NUM_SLOTS-1:0] rx_en,
    output logic [NUM_SLOTS-1:0] pend_o,
    output logic [NUM_SLOTS-1:0] req_o
);

    logic [NUM_SLOTS-1:0] pend_q;
    logic [NUM_SLOTS-1:0] dir_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
                dir_q[i]  <= 1'b0;
            end else if (done_pulse[i]) begin
                pend_q[i] <= 1'b1;          // set beats a same-cycle clear
                dir_q[i]  <= done_tx[i];
            end else if (clr_vec[i]) begin
                pend_q[i] <= 1'b0;
            end
        end

        assign req_o[i] = slot_request(pend_q[i], dir_q[i], tx_en[i], rx_en[i]);
    end

    assign pend_o = pend_q;

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (rst)
        (|done_pulse) |=> ((pend_q & $past(done_pulse)) == $past(done_pulse)));

    p_clear_only_sw_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((~pend_q & $past(pend_q) & ~$past(clr_vec)) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (|(done_pulse & clr_vec)) |=> ((pend_q & $past(done_pulse & clr_vec)) == $past(done_pulse & clr_vec)));

    p_req_needs_pend_r5: assert property (@(posedge clk) disable iff (rst)
        ((req_o & ~pend_q) == '0));

endmodule

// File: rtl/can_bus_activity.sv
module can_bus_activity #(
    parameter int unsigned NUM_RX      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_RX-1:0] rx_async,
    input  logic              clr,
    output logic              flag_o
);

    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q [NUM_RX];
    logic [NUM_RX-1:0]      prev_q;
    logic [NUM_RX-1:0]      fall;
    logic                   flag_q;

    for (genvar j = 0; j < NUM_RX; j++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[j] <= '1;             // recessive idle level
                prev_q[j] <= 1'b1;
            end else begin
                sync_q[j] <= {sync_q[j][MSB-1:0], rx_async[j]};
                prev_q[j] <= sync_q[j][MSB];
            end
        end
        assign fall[j] = prev_q[j] & ~sync_q[j][MSB];
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (|fall)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_fall_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (|fall) |=> flag_q);

    p_flag_clear_only_sw_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(clr));

endmodule

// File: rtl/can_msg_irq_agg.sv
module can_msg_irq_agg
    import can_irq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS   = 15,
    parameter int unsigned NUM_RX      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NUM_SLOTS-1:0] wr_data,
    input  logic [NUM_SLOTS-1:0] done_pulse,
    input  logic [NUM_SLOTS-1:0] done_tx,
    input  logic                 err_cond,
    input  logic                 stat_cond,
    input  logic [NUM_RX-1:0]    rx_pin,
    output logic                 can_irq,
    output logic                 act_irq,
    output logic [NUM_SLOTS-1:0] pend_o,
    output logic                 act_flag_o
);

    logic [NUM_SLOTS-1:0] tx_en_q;
    logic [NUM_SLOTS-1:0] rx_en_q;
    ctrl_t                ctrl_q;
    logic [NUM_SLOTS-1:0] clr_vec;
    logic                 act_clr;
    logic [NUM_SLOTS-1:0] slot_req;
    logic                 any_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en_q <= '0;
            rx_en_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_TX_EN: tx_en_q <= wr_data;
                REG_RX_EN: rx_en_q <= wr_data;
                REG_CTRL:  ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    assign clr_vec = (wr_en && wr_addr == REG_PEND_CLR) ? wr_data : '0;
    assign act_clr = wr_en && (wr_addr == REG_ACT_CLR) && wr_data[0];

    can_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .done_pulse (done_pulse),
        .done_tx    (done_tx),
        .clr_vec    (clr_vec),
        .tx_en      (tx_en_q),
        .rx_en      (rx_en_q),
        .pend_o     (pend_o),
        .req_o      (slot_req)
    );

    can_bus_activity #(.NUM_RX(NUM_RX), .SYNC_STAGES(SYNC_STAGES)) u_act (
        .clk      (clk),
        .rst      (rst),
        .rx_async (rx_pin),
        .clr      (act_clr),
        .flag_o   (act_flag_o)
    );

    assign any_src = (|slot_req) | (ctrl_q.err_en & err_cond) | (ctrl_q.stat_en & stat_cond);
    assign can_irq = ctrl_q.glb_en & ctrl_q.ctl_en & any_src;
    assign act_irq = ctrl_q.glb_en & ctrl_q.act_en & act_flag_o;

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
        can_irq |-> (ctrl_q.glb_en && ctrl_q.ctl_en));

    p_err_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (can_irq && (slot_req == '0) && !(ctrl_q.stat_en && stat_cond)) |-> (ctrl_q.err_en && err_cond));

    p_act_irq_r9: assert property (@(posedge clk) disable iff (rst)
        act_irq |-> (act_flag_o && ctrl_q.glb_en));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (pend_o == '0 && !act_flag_o && !can_irq && !act_irq));

endmodule

// File: tb/sim_can_msg_irq_agg.sv
module sim_can_msg_irq_agg;
    localparam int NS = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [NS-1:0] wr_data = '0;
    logic [NS-1:0] done_pulse = '0;
    logic [NS-1:0] done_tx = '0;
    logic          err_cond = 1'b0;
    logic          stat_cond = 1'b0;
    logic [1:0]    rx_pin = 2'b11;
    logic          can_irq, act_irq, act_flag_o;
    logic [NS-1:0] pend_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    can_msg_irq_agg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done_pulse(done_pulse), .done_tx(done_tx), .err_cond(err_cond),
        .stat_cond(stat_cond), .rx_pin(rx_pin), .can_irq(can_irq),
        .act_irq(act_irq), .pend_o(pend_o), .act_flag_o(act_flag_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [NS-1:0] p, input logic [NS-1:0] dir);
        done_pulse = p; done_tx = dir;
        step();
        done_pulse = '0; done_tx = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 pend", 32'(pend_o), 0);
        chk("R1 can_irq", 32'(can_irq), 0);
        chk("R1 act_flag", 32'(act_flag_o), 0);
        chk("R1 act_irq", 32'(act_irq), 0);
        pulse(NS'(1), NS'(1));
        wr(3'd3, NS'(5'b00011));
        chk("R1 enables zero", 32'(can_irq), 0);
        wr(3'd2, '1);

        // R2 R5 sweep: slot x direction x enable combos
        for (int i = 0; i < NS; i++) begin
            for (int d = 0; d < 2; d++) begin
                for (int e = 0; e < 4; e++) begin
                    logic te, re;
                    te = e[0]; re = e[1];
                    wr(3'd0, te ? NS'(1) << i : '0);
                    wr(3'd1, re ? NS'(1) << i : '0);
                    pulse(NS'(1) << i, d[0] ? NS'(1) << i : '0);
                    chk("R2 pend set", 32'(pend_o), 32'(NS'(1) << i));
                    chk("R5 slot gate", 32'(can_irq), 32'(d[0] ? te : re));
                    wr(3'd2, NS'(1) << i);
                end
            end
        end

        // R3 stickiness
        wr(3'd0, '1);
        pulse(NS'(1) << 7, NS'(1) << 7);
        repeat (5) step();
        chk("R3 holds", 32'(pend_o), 32'(NS'(1) << 7));
        wr(3'd2, ~(NS'(1) << 7));
        chk("R3 zero bit ignored", 32'(pend_o), 32'(NS'(1) << 7));
        wr(3'd1, '1);
        wr(3'd4, '1);
        chk("R3 other addr ignored", 32'(pend_o), 32'(NS'(1) << 7));
        wr(3'd2, NS'(1) << 7);
        chk("R3 cleared", 32'(pend_o), 0);

        // R4 set wins
        done_pulse = NS'(1) << 3; done_tx = '0;
        wr(3'd2, NS'(1) << 3);
        done_pulse = '0;
        chk("R4 set wins", 32'(pend_o), 32'(NS'(1) << 3));
        pulse(NS'(1) << 14, '0);
        chk("R5 multi OR", 32'(can_irq), 1);
        wr(3'd2, '1);
        chk("R5 none", 32'(can_irq), 0);

        // R6 gates
        pulse(NS'(1), NS'(1));
        for (int g = 0; g < 4; g++) begin
            wr(3'd3, NS'(g));
            chk("R6 gate", 32'(can_irq), 32'(g == 3));
        end
        wr(3'd2, '1);

        // R7 error/status sweep
        for (int k = 0; k < 16; k++) begin
            wr(3'd3, NS'({k[3:2], 2'b11}));
            err_cond = k[0]; stat_cond = k[1];
            #1;
            chk("R7 err stat", 32'(can_irq), 32'((k[0] & k[2]) | (k[1] & k[3])));
        end
        err_cond = 0; stat_cond = 0;

        // R8 bus activity
        wr(3'd3, NS'(5'b10001));
        for (int p = 0; p < 2; p++) begin
            rx_pin[p] = 1'b0;
            step(); step();
            chk("R8 not early", 32'(act_flag_o), 0);
            step();
            chk("R8 fall sets", 32'(act_flag_o), 1);
            chk("R9 act_irq", 32'(act_irq), 1);
            wr(3'd4, NS'(1));
            chk("R9 cleared", 32'(act_flag_o), 0);
            rx_pin[p] = 1'b1;
            repeat (5) step();
            chk("R8 rise ignored", 32'(act_flag_o), 0);
        end
        // R9 set wins over clear; gating
        rx_pin[1] = 1'b0;
        step(); step();
        wr(3'd4, NS'(1));
        chk("R9 set wins", 32'(act_flag_o), 1);
        wr(3'd4, '0);
        chk("R9 bit0 zero ignored", 32'(act_flag_o), 1);
        wr(3'd3, NS'(5'b10000));
        chk("R9 glb gate", 32'(act_irq), 0);
        wr(3'd3, NS'(5'b00001));
        chk("R9 act_en gate", 32'(act_irq), 0);
        rx_pin[1] = 1'b1;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule